// File: doc/BRIEF.md
# Variable Integration Flush Controller

This block drives the parallel-transfer gating of a frame-transfer CCD sensor. It decides when the image-area gate clock, the storage-area gate clock and the transfer-gate clock run. Every falling edge of an effective gate signal starts one burst with a fixed number of low pulses on all three clocks. Each burst moves a full frame of charge. Between bursts the three clocks rest high.

A mode input selects where the effective gate comes from. With the mode high, vertical drive acts as the gate, so every field is read out and the integration time is one field. With the mode low, an external gate input takes over and vertical drive no longer triggers anything. The exposure logic pulses the external gate low to flush the image area into the clearing drain, normally twice. It then holds the gate high for as long as integration should last. To read out, the mode is returned high, and the next vertical-drive low edge transfers the frame. The integration time is therefore a whole number of fields plus the interval between the last flush and that edge.

The pulse rate comes from one of two clock enables. A dump-speed input picks the faster or the slower enable. One pulse takes two enable periods: one period low, then one period high.

Top module: `flush_ctrl`

## Requirements
- R1: After a synchronous active-low reset, img_clk, stor_clk and xfer_clk are all high and no burst is running.
- R2: With use_vd high, a high-to-low change on vd_n starts one burst.
- R3: With use_vd low, changes on vd_n start no burst, and a high-to-low change on ext_gate_n starts one burst.
- R4: A burst produces exactly PULSES low pulses on each output. After the last pulse the outputs stay high until the next trigger.
- R5: With dump_fast high, the burst advances on fast_ce; with dump_fast low, it advances on slow_ce. Each low phase and each high phase lasts one period of the selected enable.
- R6: A falling gate edge that arrives while a burst is running is ignored. The burst neither restarts nor lengthens.
- R7: img_clk, stor_clk and xfer_clk carry the same waveform in every cycle.
- R8: After a flush sequence in variable mode, returning use_vd high while vd_n and ext_gate_n are both high lets the next vd_n fall start a readout burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_vd | input | 1 | 1: vertical drive is the gate; 0: external gate is used |
| vd_n | input | 1 | Vertical drive, active low |
| ext_gate_n | input | 1 | External exposure gate, active low |
| dump_fast | input | 1 | 1: burst advances on fast_ce; 0: on slow_ce |
| fast_ce | input | 1 | Clock enable at the fast dump rate |
| slow_ce | input | 1 | Clock enable at the slow dump rate |
| img_clk | output | 1 | Image-area gate clock, idle high |
| stor_clk | output | 1 | Storage-area gate clock, idle high |
| xfer_clk | output | 1 | Transfer-gate clock, idle high |

## Verification
The bench uses a short burst length and two enables with different periods, 2 and 3 cycles. This lets pulse counts and low-time totals be computed exactly and tells the rate selection apart. Triggers are applied from vertical drive in both modes and from the external gate in both modes, so each gate source is shown to work or to be ignored. A second gate edge inside a running burst separates a design that ignores it from one that restarts or extends the burst. A back-to-back flush, flush, readout sequence checks that a new burst starts cleanly after the previous one has ended.

// File: rtl/flush_pkg.sv
// Shared types for the flush controller.
package flush_pkg;
    // Output phase of the burst engine within one pulse.
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;
endpackage

// File: rtl/flush_gate_sel.sv
// Selects the effective gate (vertical drive or external gate) and flags
// its high-to-low transitions. Assumes both inputs are synchronous to clk.
module flush_gate_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic use_vd,
    input  logic vd_n,
    input  logic ext_gate_n,
    output logic fall
);
    logic gate_now;
    logic gate_q;

    // Route vertical drive or the external gate as the effective gate.
    always_comb gate_now = use_vd ? vd_n : ext_gate_n;

    // Hold the previous gate level; reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_now;
    end

    // A fall is a high previous level with a low present level.
    always_comb fall = gate_q & ~gate_now;
endmodule

// File: rtl/flush_rate_sel.sv
// Picks the step enable for the burst from NRATES clock enables.
// Assumes the enables are single-cycle strobes.
module flush_rate_sel #(
    parameter int NRATES = 2,
    localparam int SW = (NRATES > 1) ? $clog2(NRATES) : 1
) (
    input  logic [NRATES-1:0] ce,
    input  logic [SW-1:0]     sel,
    output logic              step
);
    generate
        if (NRATES == 1) begin : g_single
            // Only one rate exists: pass it through.
            always_comb step = ce[0];
        end else begin : g_multi
            // Index the enable vector with the selector.
            always_comb step = ce[sel];
        end
    endgenerate
endmodule

// File: rtl/flush_burst.sv
// Burst engine: after a trigger it emits PULSES low pulses. Each pulse is
// one step low and one step high. Triggers that arrive during a burst are
// ignored.
module flush_burst
    import flush_pkg::*;
#(
    parameter int PULSES = 302,
    localparam int CW = $clog2(PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          step,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic          out_low
);
    localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

    phase_t phase;

    // Sequence the burst: start on trigger, toggle phase on each step,
    // count finished pulses and stop after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            phase <= PH_HIGH;
        end else if (!busy) begin
            if (trig) begin
                busy  <= 1'b1;
                cnt   <= '0;
                phase <= PH_HIGH;
            end
        end else if (step) begin
            if (phase == PH_HIGH) begin
                phase <= PH_LOW;
            end else begin
                phase <= PH_HIGH;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Outputs are low only in the low phase of an active burst.
    always_comb out_low = busy && (phase == PH_LOW);
endmodule

// File: rtl/flush_ctrl.sv
// Top of the flush controller: gate selection, rate selection and burst
// engine. It drives the three parallel-transfer clocks with the same
// waveform. All inputs are assumed synchronous to clk.
module flush_ctrl #(
    parameter int PULSES = 302,
    localparam int CW = $clog2(PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_vd,
    input  logic vd_n,
    input  logic ext_gate_n,
    input  logic dump_fast,
    input  logic fast_ce,
    input  logic slow_ce,
    output logic img_clk,
    output logic stor_clk,
    output logic xfer_clk
);
    logic          trig;
    logic          step_en;
    logic          busy;
    logic [CW-1:0] burst_cnt;
    logic          out_low;

    flush_gate_sel u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_vd     (use_vd),
        .vd_n       (vd_n),
        .ext_gate_n (ext_gate_n),
        .fall       (trig)
    );

    flush_rate_sel #(.NRATES(2)) u_rate (
        .ce   ({fast_ce, slow_ce}),
        .sel  (dump_fast),
        .step (step_en)
    );

    flush_burst #(.PULSES(PULSES)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .step    (step_en),
        .busy    (busy),
        .cnt     (burst_cnt),
        .out_low (out_low)
    );

    // Fan the burst waveform out to the three transfer clocks (idle high).
    always_comb begin
        img_clk  = ~out_low;
        stor_clk = ~out_low;
        xfer_clk = ~out_low;
    end
endmodule

// File: rtl/flush_ctrl_chk.sv
// Checker for flush_ctrl, bound to every instance of the top module.
module flush_ctrl_chk #(
    parameter int PULSES = 302,
    localparam int CW = $clog2(PULSES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig,
    input logic          step_en,
    input logic          busy,
    input logic [CW-1:0] burst_cnt,
    input logic          img_clk,
    input logic          stor_clk,
    input logic          xfer_clk
);
    // R5
    fall_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(img_clk) |-> $past(step_en));

    // R5
    rise_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(img_clk) |-> $past(step_en));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cnt < CW'(PULSES));

    // R2
    start_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig));

    // R6
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_en) |=> $stable(burst_cnt) && busy);

    // R7
    same_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (img_clk == stor_clk) && (stor_clk == xfer_clk));

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) && !busy |-> img_clk);
endmodule

bind flush_ctrl flush_ctrl_chk #(.PULSES(PULSES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .step_en   (step_en),
    .busy      (busy),
    .burst_cnt (burst_cnt),
    .img_clk   (img_clk),
    .stor_clk  (stor_clk),
    .xfer_clk  (xfer_clk)
);

// File: tb/tb_flush_ctrl.sv
module tb_flush_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 7;
    localparam int FAST_P = 2;
    localparam int SLOW_P = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic use_vd = 1'b1;
    logic vd_n = 1'b1;
    logic ext_gate_n = 1'b1;
    logic dump_fast = 1'b1;
    logic fast_ce = 1'b0;
    logic slow_ce = 1'b0;
    logic img_clk, stor_clk, xfer_clk;

    int checks = 0;
    int fails = 0;
    int falls_img = 0, falls_stor = 0, falls_xfer = 0;
    int low_cycles = 0;
    int diverge = 0;
    int div_cnt = 0;
    logic prev_img = 1'b1, prev_stor = 1'b1, prev_xfer = 1'b1;

    flush_ctrl #(.PULSES(NP)) dut (
        .clk(clk), .rst_n(rst_n), .use_vd(use_vd), .vd_n(vd_n),
        .ext_gate_n(ext_gate_n), .dump_fast(dump_fast),
        .fast_ce(fast_ce), .slow_ce(slow_ce),
        .img_clk(img_clk), .stor_clk(stor_clk), .xfer_clk(xfer_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Generate the two rate enables away from the active edge.
    always @(negedge clk) begin
        div_cnt <= (div_cnt + 1) % (FAST_P * SLOW_P);
        fast_ce <= ((div_cnt + 1) % FAST_P) == 0;
        slow_ce <= ((div_cnt + 1) % SLOW_P) == 0;
    end

    // Observe the outputs mid-cycle.
    always @(negedge clk) begin
        if (prev_img && !img_clk)   falls_img++;
        if (prev_stor && !stor_clk) falls_stor++;
        if (prev_xfer && !xfer_clk) falls_xfer++;
        if (!img_clk) low_cycles++;
        if (img_clk != stor_clk || stor_clk != xfer_clk) diverge++;
        prev_img  = img_clk;
        prev_stor = stor_clk;
        prev_xfer = xfer_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        falls_img = 0; falls_stor = 0; falls_xfer = 0; low_cycles = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Check a finished burst of NP pulses at period p on all three outputs.
    task automatic check_burst(input string req, input int p);
        check(falls_img == NP,  req, falls_img, NP);
        check(falls_stor == NP, {req, "/R7"}, falls_stor, NP);
        check(falls_xfer == NP, {req, "/R7"}, falls_xfer, NP);
        check(low_cycles == NP * p, {req, "/R5"}, low_cycles, NP * p);
        check(img_clk == 1'b1, {req, "/R4 idle"}, img_clk, 1);
    endtask

    // Pulse a gate signal low for a few cycles (driven at negedge).
    task automatic pulse_vd();
        @(negedge clk); vd_n = 1'b0;
        wait_cycles(3);
        vd_n = 1'b1;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_gate_n = 1'b0;
        wait_cycles(3);
        ext_gate_n = 1'b1;
    endtask

    initial begin
        wait_cycles(4);
        // R1: reset state
        check(img_clk && stor_clk && xfer_clk, "R1", img_clk, 1);
        @(negedge clk); rst_n = 1'b1;
        wait_cycles(3);
        check(img_clk == 1'b1, "R1", img_clk, 1);

        // R2: normal mode, vd triggers burst, fast and slow rates (R5)
        for (int r = 0; r < 2; r++) begin
            dump_fast = (r == 0);
            clear_counts();
            pulse_vd();
            wait_cycles(2 * NP * SLOW_P + 10);
            check_burst("R2", (r == 0) ? FAST_P : SLOW_P);
        end

        // R3: normal mode ignores external gate
        clear_counts();
        pulse_ext();
        wait_cycles(40);
        check(falls_img == 0, "R3 ext ignored in vd mode", falls_img, 0);

        // R3: variable mode, vd ignored
        use_vd = 1'b0;
        clear_counts();
        pulse_vd();
        wait_cycles(40);
        check(falls_img == 0, "R3 vd ignored", falls_img, 0);
        check(img_clk == 1'b1, "R3 idle", img_clk, 1);

        // R3/R4: external gate flushes at both rates
        for (int r = 0; r < 2; r++) begin
            dump_fast = (r == 1);
            clear_counts();
            pulse_ext();
            wait_cycles(2 * NP * SLOW_P + 10);
            check_burst("R3", (r == 1) ? FAST_P : SLOW_P);
        end

        // R6: retrigger in mid burst is ignored
        dump_fast = 1'b0;
        clear_counts();
        pulse_ext();
        wait_cycles(8);
        pulse_ext();
        wait_cycles(2 * NP * SLOW_P + 10);
        check_burst("R6", SLOW_P);

        // R8: two flushes, then readout via vertical drive
        dump_fast = 1'b1;
        clear_counts();
        pulse_ext();
        wait_cycles(2 * NP * FAST_P + 6);
        pulse_ext();
        wait_cycles(2 * NP * FAST_P + 6);
        check(falls_img == 2 * NP, "R8 flushes", falls_img, 2 * NP);
        clear_counts();
        wait_cycles(30);
        check(falls_img == 0, "R8 integrating", falls_img, 0);
        use_vd = 1'b1;
        wait_cycles(5);
        check(falls_img == 0, "R8 mode switch", falls_img, 0);
        pulse_vd();
        wait_cycles(2 * NP * FAST_P + 10);
        check_burst("R8", FAST_P);

        // R7: no divergence at any sampled cycle
        check(diverge == 0, "R7", diverge, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule